// File: doc/BRIEF.md
# I/Q DC Offset Calibration Controller

This block trims the DC offset of the I and Q transmit DAC channels with a closed feedback loop. Each channel has its own 8-bit two's complement offset register whose value is added by the DAC to the transmit samples. A calibration request input starts a trim, but only while the uplink window input is also high. During the trim the block forces both digital sample outputs to zero, so each DAC output carries only its offset register. One comparator bit per channel reports the sign of the sensed analog DC level.

Both channels run a successive-approximation search in parallel. The search tests one bit per settle period, starting with the most significant bit. The settle period is a programmable number of clocks, so the analog path can settle before the comparator is read. The registers keep their final values after the trim ends, and normal transmit data passes through unchanged. If the request drops early, the bits resolved so far are kept and an incomplete flag is raised. A path power-down input freezes the loop without losing its state.

Top module: `iq_offset_cal`

## Requirements
- R1: After reset both offset outputs read 0, and `calBusy`, `calDone` and `calIncomplete` are low.
- R2: A trim starts only on a clock edge where `calReq` and `winOn` are both high. With either input low, `calReq` has no effect on the offsets or on the sample path.
- R3: While `calBusy` is high, `iSampleOut` and `qSampleOut` are zero. Otherwise they equal `iSampleIn` and `qSampleIn`.
- R4: The search works on the offset-binary code, where offset = code XOR 0x80. It starts at code 0x80 (offset 0) and tests bits 7 down to 0. The trial bit is kept when the comparator input is 1, which means the sensed level is at or below zero and the offset is not yet too high. With a comparator that reads 1 exactly when offset <= T, the final offset equals T for every T in -128..127.
- R5: One bit is decided per settle period of `settleCycles` clocks, and 0 counts as 1. `calDone` is seen 8*S+1 clock edges after the trim is requested, counting the start edge.
- R6: The I and Q channels are searched in parallel from their own comparator inputs. Each channel's result depends only on its own comparator.
- R7: If `calReq` or `winOn` falls during a trim, the trim stops. The resolved bits are kept, the pending trial bit is cleared and `calIncomplete` is set. The flag clears when the next trim starts.
- R8: While `pathPd` is high during a trim, the offsets and the search progress hold and `calBusy` stays high. The search resumes and completes normally when `pathPd` falls.
- R9: After a trim, the offsets hold their values while no trim is running. A new trim needs `calReq` and `winOn` to drop and then rise together again. Keeping them high after completion has no effect.
- R10: `calDone` is a single-cycle pulse at the end of a complete trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| calReq | input | 1 | Calibration request |
| winOn | input | 1 | Uplink window active |
| pathPd | input | 1 | Path power-down; freezes the loop |
| settleCycles | input | SETTLE_W | Clocks per bit decision (0 acts as 1) |
| cmpI | input | 1 | I comparator: 1 = DC level at or below zero |
| cmpQ | input | 1 | Q comparator: 1 = DC level at or below zero |
| iSampleIn | input | SMP_W | I transmit sample |
| qSampleIn | input | SMP_W | Q transmit sample |
| iSampleOut | output | SMP_W | I sample to DAC, zero during trim |
| qSampleOut | output | SMP_W | Q sample to DAC, zero during trim |
| iOffset | output | OFS_W | I offset register, two's complement |
| qOffset | output | OFS_W | Q offset register, two's complement |
| calBusy | output | 1 | Trim in progress |
| calDone | output | 1 | One-cycle pulse when a trim completes |
| calIncomplete | output | 1 | Last trim was cut short |

## Verification
The comparator is modelled from the offset outputs and a hidden target per channel. The targets include both range ends, zero and unequal I and Q values, so a wrong keep polarity, a wrong bit order or cross-coupled channels each give a different final code. Settle values of 0, 1 and 4 separate a correct decision period from one that is off by one, and an early drop after two decisions checks that only resolved bits survive. A power-down pause in mid-trim and a request held high after completion show whether the loop advances or restarts when it must not.

// File: rtl/iq_cal_pkg.sv
package iq_cal_pkg;
  typedef enum logic [1:0] {CAL_IDLE, CAL_RUN, CAL_HOLD} calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;   // load mid-scale code, point at top bit
    logic decide;  // resolve the current bit from the comparator
    logic abort;   // drop the pending trial bit, stop
  } calStrobe_t;
endpackage

// File: rtl/iq_cal_ctrl.sv
module iq_cal_ctrl
  import iq_cal_pkg::*;
#(
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                calReq,
  input  logic                winOn,
  input  logic                pathPd,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                lastBit,
  output calStrobe_t          strobe,
  output logic                busy,
  output logic                calDone,
  output logic                calIncomplete
);
  calState_t state;
  logic [SETTLE_W-1:0] cnt;
  logic [SETTLE_W-1:0] limitM1;
  logic active, stepDue;

  assign active  = calReq & winOn;
  assign limitM1 = (settleCycles == '0) ? '0 : settleCycles - 1'b1;
  assign stepDue = (cnt == limitM1);
  assign busy    = (state == CAL_RUN);

  always_comb begin
    strobe.start  = (state == CAL_IDLE) && active;
    strobe.abort  = (state == CAL_RUN) && !active;
    strobe.decide = (state == CAL_RUN) && active && !pathPd && stepDue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= CAL_IDLE;
      cnt           <= '0;
      calDone       <= 1'b0;
      calIncomplete <= 1'b0;
    end else begin
      calDone <= strobe.decide && lastBit;
      unique case (state)
        CAL_IDLE: if (strobe.start) begin
          state         <= CAL_RUN;
          cnt           <= '0;
          calIncomplete <= 1'b0;
        end
        CAL_RUN: begin
          if (strobe.abort) begin
            state         <= CAL_IDLE;
            calIncomplete <= 1'b1;
          end else if (!pathPd) begin
            if (stepDue) begin
              cnt <= '0;
              if (lastBit) state <= CAL_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        CAL_HOLD: if (!active) state <= CAL_IDLE;
        default: state <= CAL_IDLE;
      endcase
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(calReq && winOn)); // R2
  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(calReq && winOn)) |=> (!busy && calIncomplete)); // R7
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && calReq && winOn && pathPd) |=> (busy && $stable(cnt))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    calDone |=> !calDone); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    calDone |-> (!busy && !calIncomplete)); // R10
endmodule

// File: rtl/iq_cal_dp.sv
module iq_cal_dp
  import iq_cal_pkg::*;
#(
  parameter int unsigned OFS_W = 8,
  parameter int unsigned SMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  calStrobe_t       strobe,
  input  logic             busy,
  input  logic             cmpI,
  input  logic             cmpQ,
  input  logic [SMP_W-1:0] iSampleIn,
  input  logic [SMP_W-1:0] qSampleIn,
  output logic [SMP_W-1:0] iSampleOut,
  output logic [SMP_W-1:0] qSampleOut,
  output logic [OFS_W-1:0] iOffset,
  output logic [OFS_W-1:0] qOffset,
  output logic             lastBit
);
  localparam int unsigned NCH = 2;
  localparam logic [OFS_W-1:0] MID = {1'b1, {(OFS_W-1){1'b0}}};

  logic [OFS_W-1:0] ptr;
  logic [OFS_W-1:0] code   [NCH];
  logic             cmpVec [NCH];
  logic [SMP_W-1:0] smpIn  [NCH];
  logic [SMP_W-1:0] smpOut [NCH];

  assign cmpVec[0] = cmpI;
  assign cmpVec[1] = cmpQ;
  assign smpIn[0]  = iSampleIn;
  assign smpIn[1]  = qSampleIn;
  assign lastBit   = ptr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ptr <= '0;
    else if (strobe.start)  ptr <= MID;
    else if (strobe.abort)  ptr <= '0;
    else if (strobe.decide) ptr <= ptr >> 1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code[ch] <= MID;
      end else if (strobe.start) begin
        code[ch] <= MID;
      end else if (strobe.abort) begin
        code[ch] <= code[ch] & ~ptr;
      end else if (strobe.decide) begin
        code[ch] <= (cmpVec[ch] ? code[ch] : (code[ch] & ~ptr)) | (ptr >> 1);
      end
    end
    assign smpOut[ch] = busy ? '0 : smpIn[ch];
  end

  assign iOffset    = code[0] ^ MID;
  assign qOffset    = code[1] ^ MID;
  assign iSampleOut = smpOut[0];
  assign qSampleOut = smpOut[1];

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr)); // R4
  AST_PTR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(ptr) == 1)); // R5
  AST_START_MID: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.start |=> (code[0] == MID && code[1] == MID)); // R4
endmodule

// File: rtl/iq_offset_cal.sv
module iq_offset_cal
  import iq_cal_pkg::*;
#(
  parameter int unsigned OFS_W    = 8,
  parameter int unsigned SMP_W    = 12,
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                calReq,
  input  logic                winOn,
  input  logic                pathPd,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                cmpI,
  input  logic                cmpQ,
  input  logic [SMP_W-1:0]    iSampleIn,
  input  logic [SMP_W-1:0]    qSampleIn,
  output logic [SMP_W-1:0]    iSampleOut,
  output logic [SMP_W-1:0]    qSampleOut,
  output logic [OFS_W-1:0]    iOffset,
  output logic [OFS_W-1:0]    qOffset,
  output logic                calBusy,
  output logic                calDone,
  output logic                calIncomplete
);
  calStrobe_t strobe;
  logic lastBit;

  iq_cal_ctrl #(.SETTLE_W(SETTLE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .calReq(calReq), .winOn(winOn), .pathPd(pathPd),
    .settleCycles(settleCycles), .lastBit(lastBit), .strobe(strobe),
    .busy(calBusy), .calDone(calDone), .calIncomplete(calIncomplete)
  );

  iq_cal_dp #(.OFS_W(OFS_W), .SMP_W(SMP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .busy(calBusy),
    .cmpI(cmpI), .cmpQ(cmpQ), .iSampleIn(iSampleIn), .qSampleIn(qSampleIn),
    .iSampleOut(iSampleOut), .qSampleOut(qSampleOut),
    .iOffset(iOffset), .qOffset(qOffset), .lastBit(lastBit)
  );

  AST_OFFSET_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!calBusy && $past(!calBusy)) |-> ($stable(iOffset) && $stable(qOffset))); // R9
  AST_ZERO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (calBusy && iSampleIn != '0) |-> (iSampleOut != iSampleIn)); // R3
endmodule

// File: tb/tb_iq_offset_cal.sv
`timescale 1ns/1ps
module tb_iq_offset_cal;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic calReq = 1'b0, winOn = 1'b0, pathPd = 1'b0;
  logic [7:0] settle = 8'd4;
  logic cmpI, cmpQ;
  logic [11:0] iSampleIn = 12'h5A3, qSampleIn = 12'h1C7;
  logic [11:0] iSampleOut, qSampleOut;
  logic [7:0] iOffset, qOffset;
  logic calBusy, calDone, calIncomplete;
  int tI = 0, tQ = 0;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] i;
    logic [7:0] q;
    logic       inc;
    string      tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  // comparator model: 1 when DC level (offset - target) is at or below zero
  assign cmpI = ($signed(iOffset) <= tI);
  assign cmpQ = ($signed(qOffset) <= tQ);

  iq_offset_cal dut (
    .clk(clk), .rst_n(rst_n), .calReq(calReq), .winOn(winOn), .pathPd(pathPd),
    .settleCycles(settle), .cmpI(cmpI), .cmpQ(cmpQ),
    .iSampleIn(iSampleIn), .qSampleIn(qSampleIn),
    .iSampleOut(iSampleOut), .qSampleOut(qSampleOut),
    .iOffset(iOffset), .qOffset(qOffset),
    .calBusy(calBusy), .calDone(calDone), .calIncomplete(calIncomplete)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] sarModel(input int t, input int nb);
    logic [7:0] u, tr;
    u = 8'h00;
    for (int k = 7; k > 7 - nb; k--) begin
      tr = u | (8'd1 << k);
      if ($signed(tr ^ 8'h80) <= t) u = tr;
    end
    return u ^ 8'h80;
  endfunction

  // monitor: compare at each end of a trim
  bit prevBusy = 0;
  always @(negedge clk) begin
    if (prevBusy && !calBusy) begin
      if (sbQ.size() == 0) begin
        check(0, "R4 unexpected trim end", 1, 0);
      end else begin
        expItem_t e;
        e = sbQ.pop_front();
        check(iOffset == e.i, {e.tag, " I offset"}, $signed(iOffset), $signed(e.i));
        check(qOffset == e.q, {e.tag, " Q offset"}, $signed(qOffset), $signed(e.q));
        check(calIncomplete == e.inc, {e.tag, " incomplete flag"}, calIncomplete, e.inc);
      end
    end
    prevBusy = calBusy;
  end

  // full trim with optional mid-trim freeze
  task automatic runFull(input int s, input int ti, input int tq, input int freezeCyc, input string tag);
    int eff, cnt;
    logic [7:0] hi, hq;
    expItem_t e;
    eff = (s == 0) ? 1 : s;
    settle = s[7:0]; tI = ti; tQ = tq;
    e.i = ti[7:0]; e.q = tq[7:0]; e.inc = 1'b0; e.tag = tag;
    sbQ.push_back(e);
    @(negedge clk); winOn = 1'b1; calReq = 1'b1;
    cnt = 0;
    @(posedge clk); cnt++; @(negedge clk);
    check(calBusy == 1'b1, "R2 trim started", calBusy, 1);
    check(iSampleOut == 0 && qSampleOut == 0, "R3 samples forced to zero", iSampleOut, 0);
    if (freezeCyc > 0) begin
      pathPd = 1'b1;
      @(posedge clk); @(negedge clk);
      hi = iOffset; hq = qOffset;
      repeat (freezeCyc) @(posedge clk);
      @(negedge clk);
      check(iOffset == hi && qOffset == hq, "R8 offsets frozen", iOffset, hi);
      check(calBusy == 1'b1, "R8 busy during freeze", calBusy, 1);
      check(iSampleOut == 0, "R8 R3 zero forced while frozen", iSampleOut, 0);
      pathPd = 1'b0;
    end
    while (!calDone && cnt < 5000) begin
      @(posedge clk); cnt++; @(negedge clk);
    end
    if (freezeCyc == 0)
      check(cnt == 8 * eff + 1, "R5 done timing", cnt, 8 * eff + 1);
    check(calDone == 1'b1, "R10 done seen", calDone, 1);
    @(posedge clk); @(negedge clk);
    check(calDone == 1'b0, "R10 done one cycle", calDone, 0);
  endtask

  task automatic releaseReq();
    @(negedge clk); calReq = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(iOffset == 0 && qOffset == 0, "R1 reset offsets", iOffset, 0);
    check(!calBusy && !calDone && !calIncomplete, "R1 reset flags",
          {calBusy, calDone, calIncomplete}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(iSampleOut == iSampleIn && qSampleOut == qSampleIn, "R3 passthrough idle",
          iSampleOut, iSampleIn);

    // R2: request without window is ignored
    calReq = 1'b1; winOn = 1'b0; tI = 50; tQ = -50;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(!calBusy && iOffset == 0 && qOffset == 0, "R2 no start without window",
          calBusy, 0);
    check(iSampleOut == iSampleIn, "R2 R3 samples untouched", iSampleOut, iSampleIn);
    calReq = 1'b0; winOn = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!calBusy, "R2 no start without request", calBusy, 0);

    // R4 R6: full trims with distinct targets
    runFull(4, 37, -90, 0, "R4 R6 run s4");
    // R9: held request does not restart, offsets kept
    tI = -5; tQ = 100;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(!calBusy && iOffset == 8'd37, "R9 no restart while held", $signed(iOffset), 37);
    check(iSampleOut == iSampleIn, "R9 R3 passthrough after trim", iSampleOut, iSampleIn);
    releaseReq();

    runFull(1, 127, -128, 0, "R4 range ends s1");
    releaseReq();
    runFull(0, 0, 1, 0, "R5 settle zero");
    releaseReq();
    runFull(4, -1, -1, 0, "R6 equal targets");
    releaseReq();

    // R7: early drop after two decisions
    begin
      expItem_t e;
      settle = 8'd4; tI = 77; tQ = -33;
      e.i = sarModel(77, 2); e.q = sarModel(-33, 2); e.inc = 1'b1; e.tag = "R7 abort";
      sbQ.push_back(e);
      @(negedge clk); winOn = 1'b1; calReq = 1'b1;
      @(posedge clk);
      repeat (8) @(posedge clk);
      @(negedge clk); calReq = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(calIncomplete == 1'b1, "R7 incomplete raised", calIncomplete, 1);
    end

    // R7: flag clears on next start; R8 freeze in mid-trim
    runFull(4, -64, 64, 25, "R7 R8 freeze run");
    check(!calIncomplete, "R7 flag cleared", calIncomplete, 0);
    releaseReq();

    // R7: window drop also aborts
    begin
      expItem_t e;
      settle = 8'd2; tI = 10; tQ = 20;
      e.i = sarModel(10, 1); e.q = sarModel(20, 1); e.inc = 1'b1; e.tag = "R7 window abort";
      sbQ.push_back(e);
      @(negedge clk); calReq = 1'b1;
      @(posedge clk);
      repeat (2) @(posedge clk);
      @(negedge clk); winOn = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      calReq = 1'b0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sbQ.size() == 0, "R4 all trims observed", sbQ.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule